// File: doc/BRIEF.md
# Wave Table Sound Channel

This block is a sound channel that plays a short user-defined waveform. The waveform is 32 four-bit samples held in a 16-byte pattern store. A programmable period counter is advanced by a channel clock strobe. Each time the counter expires, the channel steps a 5-bit sample position. On even positions it also fetches a byte from the store into a latch. The current nibble of that latch, attenuated by a 2-bit volume code, is the channel's sample output.

A byte-wide CPU port reads and writes the pattern store. The port takes a single-cycle request, and read data comes back combinationally in the same cycle. While the channel is disabled, the port addresses the store directly. While the channel plays, every access is redirected to the byte the channel is working on, whatever address is given. A strictness input selects how these redirected accesses behave:
- In relaxed mode they always succeed.
- In strict mode they succeed only on the exact cycle of a fetch. At any other cycle, reads return 0xFF and writes are dropped.

Top module: `wave_chan`

## Requirements
- R1: While `chan_en_i` is low, a request with `cpu_we_i` high stores `cpu_wdata_i` at byte `cpu_addr_i` (0 to 15) at the clock edge. `cpu_rdata_o` shows the byte at `cpu_addr_i` in the same cycle.
- R2: While disabled, the position is 0 and the period counter holds `period_i`. While enabled, each cycle with `tick_i` high decrements the counter. A tick that finds the counter at 0 is an expiry and reloads the counter from `period_i`, so expiries are `period_i`+1 ticks apart. Cycles with `tick_i` low change nothing.
- R3: An expiry at an even position p fetches byte p/2 into the latch. Every expiry increments the position, and the position wraps from 31 to 0.
- R4: With volume code 1, `sample_o` is latch bits [3:0] when the position is odd and latch bits [7:4] when it is even.
- R5: Volume codes 0, 1, 2 and 3 right-shift the selected nibble by 4, 0, 1 and 2 bits respectively. Code 0 therefore gives 0.
- R6: In relaxed mode (`strict_i` low), outside a fetch cycle, an enabled channel returns the latch on reads for any address. A write replaces both the latch and the byte that was last fetched (byte 0 if nothing has been fetched since enable).
- R7: In strict mode (`strict_i` high), outside a fetch cycle, an enabled channel returns 0xFF on reads, and writes change neither the store nor the latch.
- R8: On a fetch cycle, in either mode, a read returns the byte being fetched. A write lands after the fetch: it replaces that byte in both the store and the latch.
- R9: After reset, the store, latch, position and counter are all 0.
- R10: While the channel is disabled, the latch is cleared, so `sample_o` is 0 and the first redirected relaxed read after enable returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chan_en_i | input | 1 | Channel enable (level) |
| tick_i | input | 1 | Channel clock strobe |
| period_i | input | PERIOD_W | Reload value of the period counter |
| vol_i | input | 2 | Volume code |
| strict_i | input | 1 | 1 selects strict redirected access |
| cpu_req_i | input | 1 | CPU access request |
| cpu_we_i | input | 1 | CPU write enable |
| cpu_addr_i | input | IDX_W | CPU byte address |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_rdata_o | output | 8 | CPU read data, same cycle |
| sample_o | output | 4 | Attenuated sample |

## Verification
The bench builds the block with its defaults: 16 pattern bytes and an 11-bit period. With periods kept between 0 and 5, the position wraps past 31 many times within a few thousand cycles. Strict-mode fetch cycles occur often enough that reads and writes coincide with them regularly. Period 0 with a continuous tick makes fetch cycles and odd-position cycles alternate back to back. Gating the tick and toggling the enable at random exercises the counter hold, the position clear and the latch clear against the reference model.

// File: rtl/wave_pkg.sv
package wave_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NIB_W  = BYTE_W / 2;
  localparam int unsigned VOL_W  = 2;

  // volume code -> right shift of the nibble
  function automatic logic [2:0] vol_shift(input logic [VOL_W-1:0] code);
    case (code)
      2'd0:    return 3'd4;
      2'd1:    return 3'd0;
      2'd2:    return 3'd1;
      default: return 3'd2;
    endcase
  endfunction
endpackage

// File: rtl/wave_seq.sv
module wave_seq #(
  parameter int unsigned PERIOD_W = 11,
  parameter int unsigned POS_W    = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                tick_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic [POS_W-1:0]    pos_o,
  output logic                expire_o,
  output logic                fetch_o
);
  logic [PERIOD_W-1:0] cnt_q;
  logic [POS_W-1:0]    pos_q;

  assign expire_o = en_i & tick_i & (cnt_q == '0);
  assign fetch_o  = expire_o & ~pos_q[0];
  assign pos_o    = pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      pos_q <= '0;
    end else if (!en_i) begin
      cnt_q <= period_i;
      pos_q <= '0;
    end else if (tick_i) begin
      if (cnt_q == '0) begin
        cnt_q <= period_i;
        pos_q <= pos_q + 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/wave_ram.sv
module wave_ram
  import wave_pkg::*;
#(
  parameter int unsigned NUM_BYTES = 16,
  parameter int unsigned IDX_W     = $clog2(NUM_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              strict_i,
  input  logic              fetch_i,
  input  logic [IDX_W-1:0]  fetch_idx_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic [BYTE_W-1:0] latch_o
);
  logic [BYTE_W-1:0] mem_q [NUM_BYTES];
  logic [BYTE_W-1:0] latch_q;
  logic [IDX_W-1:0]  lidx_q;
  logic              wr_ok;
  logic [IDX_W-1:0]  wr_idx;

  // write steering: direct, fetch cycle, relaxed redirect, strict drop
  always_comb begin
    wr_ok  = req_i & we_i;
    wr_idx = lidx_q;
    if (!en_i)          wr_idx = addr_i;
    else if (fetch_i)   wr_idx = fetch_idx_i;
    else if (strict_i)  wr_ok  = 1'b0;
  end

  always_comb begin
    if (!en_i)         rdata_o = mem_q[addr_i];
    else if (fetch_i)  rdata_o = mem_q[fetch_idx_i];
    else if (strict_i) rdata_o = '1;
    else               rdata_o = latch_q;
  end

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                mem_q[g] <= '0;
      else if (wr_ok && wr_idx == IDX_W'(g))      mem_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
      lidx_q  <= '0;
    end else if (!en_i) begin
      latch_q <= '0;
      lidx_q  <= '0;
    end else if (fetch_i) begin
      lidx_q  <= fetch_idx_i;
      latch_q <= wr_ok ? wdata_i : mem_q[fetch_idx_i];
    end else if (wr_ok) begin
      latch_q <= wdata_i;
    end
  end

  assign latch_o = latch_q;
endmodule

// File: rtl/wave_shape.sv
module wave_shape
  import wave_pkg::*;
(
  input  logic [BYTE_W-1:0] latch_i,
  input  logic              pos_lsb_i,
  input  logic [VOL_W-1:0]  vol_i,
  output logic [NIB_W-1:0]  sample_o
);
  logic [NIB_W-1:0] nib;

  assign nib      = pos_lsb_i ? latch_i[NIB_W-1:0] : latch_i[BYTE_W-1:NIB_W];
  assign sample_o = nib >> vol_shift(vol_i);
endmodule

// File: rtl/wave_chan.sv
module wave_chan
  import wave_pkg::*;
#(
  parameter int unsigned NUM_BYTES = 16,
  parameter int unsigned PERIOD_W  = 11,
  localparam int unsigned IDX_W    = $clog2(NUM_BYTES),
  localparam int unsigned POS_W    = IDX_W + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                chan_en_i,
  input  logic                tick_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic [1:0]          vol_i,
  input  logic                strict_i,
  input  logic                cpu_req_i,
  input  logic                cpu_we_i,
  input  logic [IDX_W-1:0]    cpu_addr_i,
  input  logic [7:0]          cpu_wdata_i,
  output logic [7:0]          cpu_rdata_o,
  output logic [3:0]          sample_o
);
  logic [POS_W-1:0]  pos;
  logic              expire;
  logic              fetch;
  logic [BYTE_W-1:0] latch;

  wave_seq #(.PERIOD_W(PERIOD_W), .POS_W(POS_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (chan_en_i),
    .tick_i   (tick_i),
    .period_i (period_i),
    .pos_o    (pos),
    .expire_o (expire),
    .fetch_o  (fetch)
  );

  wave_ram #(.NUM_BYTES(NUM_BYTES), .IDX_W(IDX_W)) u_ram (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (chan_en_i),
    .strict_i    (strict_i),
    .fetch_i     (fetch),
    .fetch_idx_i (pos[POS_W-1:1]),
    .req_i       (cpu_req_i),
    .we_i        (cpu_we_i),
    .addr_i      (cpu_addr_i),
    .wdata_i     (cpu_wdata_i),
    .rdata_o     (cpu_rdata_o),
    .latch_o     (latch)
  );

  wave_shape u_shape (
    .latch_i   (latch),
    .pos_lsb_i (pos[0]),
    .vol_i     (vol_i),
    .sample_o  (sample_o)
  );
endmodule

// File: rtl/wave_chan_chk.sv
module wave_chan_chk #(
  parameter int unsigned POS_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             chan_en_i,
  input logic             strict_i,
  input logic             cpu_req_i,
  input logic             cpu_we_i,
  input logic [1:0]       vol_i,
  input logic [7:0]       cpu_rdata_o,
  input logic [3:0]       sample_o,
  input logic [POS_W-1:0] pos,
  input logic             expire,
  input logic             fetch,
  input logic [7:0]       latch
);
  AST_POS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chan_en_i |=> pos == '0); // R2
  AST_POS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_en_i && !expire) |=> $stable(pos)); // R2
  AST_POS_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_en_i && expire) |=> pos == POS_W'($past(pos) + 1'b1)); // R3
  AST_MUTE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vol_i == 2'd0) |-> sample_o == 4'd0); // R5
  AST_RELAXED_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_en_i && !strict_i && !fetch) |-> cpu_rdata_o == latch); // R6
  AST_STRICT_FF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_en_i && strict_i && !fetch) |-> cpu_rdata_o == 8'hFF); // R7
  AST_STRICT_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_en_i && strict_i && !fetch && cpu_req_i && cpu_we_i) |=> $stable(latch)); // R7
  AST_LATCH_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chan_en_i |=> latch == 8'h00); // R10
endmodule

bind wave_chan wave_chan_chk #(.POS_W(POS_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .chan_en_i   (chan_en_i),
  .strict_i    (strict_i),
  .cpu_req_i   (cpu_req_i),
  .cpu_we_i    (cpu_we_i),
  .vol_i       (vol_i),
  .cpu_rdata_o (cpu_rdata_o),
  .sample_o    (sample_o),
  .pos         (pos),
  .expire      (expire),
  .fetch       (fetch),
  .latch       (latch)
);

// File: tb/wave_chan_tb_top.sv
module wave_chan_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        chan_en_i, tick_i, strict_i, cpu_req_i, cpu_we_i;
  logic [10:0] period_i;
  logic [1:0]  vol_i;
  logic [3:0]  cpu_addr_i;
  logic [7:0]  cpu_wdata_i, cpu_rdata_o;
  logic [3:0]  sample_o;

  int n_chk = 0;
  int n_fail = 0;

  // reference model state
  int m_mem[16];
  int m_pos, m_cnt, m_latch, m_lidx;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  wave_chan dut_i (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int vol_sh(input int v);
    case (v)
      0: return 4;
      1: return 0;
      2: return 1;
      default: return 2;
    endcase
  endfunction

  task automatic cyc(input bit en, input bit tk, input int per, input int vol,
                     input bit st, input bit req, input bit we, input int addr,
                     input int wd);
    bit fetch;
    int exp_rd, nib, widx;
    chan_en_i = en; tick_i = tk; period_i = 11'(per); vol_i = 2'(vol);
    strict_i = st; cpu_req_i = req; cpu_we_i = we;
    cpu_addr_i = 4'(addr); cpu_wdata_i = 8'(wd);
    #1;
    fetch = en && tk && m_cnt == 0 && (m_pos % 2) == 0;
    if (!en)       exp_rd = m_mem[addr];
    else if (fetch) exp_rd = m_mem[m_pos / 2];
    else if (st)   exp_rd = 'hFF;
    else           exp_rd = m_latch;
    if (req) begin
      if (!en)        chk("R1 direct read", cpu_rdata_o, exp_rd);
      else if (fetch) chk("R8 fetch-cycle read", cpu_rdata_o, exp_rd);
      else if (st)    chk("R7 strict read", cpu_rdata_o, exp_rd);
      else            chk("R6 relaxed read", cpu_rdata_o, exp_rd);
    end
    nib = (m_pos % 2) ? (m_latch & 15) : (m_latch >> 4);
    if (!en)           chk("R10 sample while disabled", sample_o, nib >> vol_sh(vol));
    else if (vol == 1) chk("R2 R3 R4 sample", sample_o, nib);
    else               chk("R5 attenuated sample", sample_o, nib >> vol_sh(vol));
    @(posedge clk_i);
    if (!en) begin
      m_pos = 0; m_cnt = per; m_latch = 0; m_lidx = 0;
      if (req && we) m_mem[addr] = wd;
    end else begin
      if (tk) begin
        if (m_cnt == 0) begin
          m_cnt = per;
          if (m_pos % 2 == 0) begin
            m_lidx = m_pos / 2;
            m_latch = m_mem[m_lidx];
          end
          m_pos = (m_pos + 1) % 32;
        end else m_cnt--;
      end
      widx = m_lidx;
      if (req && we && (fetch || !st)) begin
        m_mem[widx] = wd;
        m_latch = wd;
      end
    end
    @(negedge clk_i);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    chan_en_i = 0; tick_i = 0; strict_i = 0; cpu_req_i = 0; cpu_we_i = 0;
    period_i = '0; vol_i = 2'd1; cpu_addr_i = '0; cpu_wdata_i = '0;
    for (int i = 0; i < 16; i++) m_mem[i] = 0;
    m_pos = 0; m_cnt = 0; m_latch = 0; m_lidx = 0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R9 reset state
    cpu_req_i = 1; cpu_addr_i = 4'd7; #1;
    chk("R9 reset store", cpu_rdata_o, 0);
    chk("R9 reset sample", sample_o, 0);
    @(negedge clk_i);

    // R1 direct writes then read back
    for (int i = 0; i < 16; i++) cyc(0, 1, 3, 1, 0, 1, 1, i, (i * 37 + 11) & 255);
    for (int i = 15; i >= 0; i--) cyc(0, 1, 3, 1, 0, 1, 0, i, 0);

    // relaxed play, reads only
    for (int i = 0; i < 200; i++) cyc(1, 1, 3, i % 4, 0, 1, 0, $urandom % 16, 0);
    cyc(0, 0, 2, 1, 0, 0, 0, 0, 0);
    // strict play, reads only
    for (int i = 0; i < 200; i++) cyc(1, 1, 2, 1, 1, 1, 0, $urandom % 16, 0);
    cyc(0, 0, 1, 1, 1, 0, 0, 0, 0);
    // strict with writes and gated tick
    for (int i = 0; i < 300; i++)
      cyc(1, ($urandom % 2) == 1, 1, $urandom % 4, 1, 1, ($urandom % 2) == 1,
          $urandom % 16, $urandom % 256);
    cyc(0, 0, 0, 1, 0, 0, 0, 0, 0);
    // relaxed, period 0, writes
    for (int i = 0; i < 200; i++)
      cyc(1, 1, 0, 1, 0, 1, ($urandom % 3) == 0, $urandom % 16, $urandom % 256);
    // everything random
    for (int i = 0; i < 1500; i++)
      cyc(($urandom % 20) != 0, ($urandom % 4) != 0, $urandom % 6, $urandom % 4,
          ($urandom % 2) == 1, ($urandom % 4) != 0, ($urandom % 4) == 0,
          $urandom % 16, $urandom % 256);
    // final direct read back
    for (int i = 0; i < 16; i++) cyc(0, 1, 2, 1, 0, 1, 0, i, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule